// File: doc/BRIEF.md
# Tagged Read-Data Receiver

This block sits on the host side of a byte-serial register and memory link. It handles the data phase of a read. The byte stream it receives may hold any number of filler bytes before a start byte, which is marked by its upper nibble. The block searches for that start byte within a bounded window. It then forwards a fixed number of payload bytes with a valid strobe. When checking is on, it compares the two check bytes that follow each packet against a CRC it computes while the payload passes through.

A transfer begins with a one-cycle `start` pulse. The controller chooses one of two modes. A single-register read always yields four payload bytes. A block read yields `blk_len` bytes, cut into packets of `PKT_BYTES`, and each packet has its own start byte and its own optional check. The block ends the transfer with exactly one pulse on `done`, `miss_err` or `crc_err`. The command phase that comes before the data phase is handled elsewhere.

Top module: `rdtag_rx`

## Requirements
- R1: After reset, `busy`, `out_valid`, `done`, `miss_err` and `crc_err` are all low.
- R2: A start byte is any byte whose bits [7:4] are 4'b1111, whatever its low nibble. Before the start byte, bytes with any other upper nibble are skipped and never appear on `out_valid`.
- R3: In a single read the start byte must be one of the first 8 bytes received after `start`. When the 8th byte is not a start byte, `miss_err` pulses for one cycle and the block returns to idle with `busy` low.
- R4: A single read forwards exactly the 4 bytes that follow the start byte, in arrival order, each with one `out_valid` cycle.
- R5: A block read forwards `blk_len` bytes in packets of `PKT_BYTES`, and the last packet carries the remainder. A fresh start-byte search precedes each packet.
- R6: In a block read, each packet's start byte must be among the first 100 bytes of its search. When the 100th byte is not a start byte, `miss_err` pulses and the transfer is aborted.
- R7: When `crc_on` is set, two check bytes follow each packet, high byte first. They must equal the CRC of that packet's payload: polynomial 0x1021, initial value 0xFFFF, data taken MSB first, no final inversion. A mismatch pulses `crc_err` and aborts the transfer, and no `done` follows.
- R8: For a single read with `clockless` set, no check bytes are expected even if `crc_on` is set, so `done` follows the 4th payload byte.
- R9: `done` is high for one cycle, in the cycle after the block accepts the final byte of the transfer. This final byte is the last payload byte, or the low check byte when checking is on. `busy` is low in that same cycle.
- R10: A `start` pulse while `busy` is high has no effect on the transfer in progress. Input bytes presented while idle are ignored.
- R11: A block read started with `blk_len` = 0 consumes no bytes and pulses `done` in the cycle after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a transfer when idle |
| single_rd | input | 1 | 1: single-register read (4 bytes); 0: block read |
| clockless | input | 1 | Single read of a clockless register; suppresses the check |
| crc_on | input | 1 | Expect and check two CRC bytes after each packet |
| blk_len | input | LENW | Total payload bytes of a block read |
| in_valid | input | 1 | A received byte is present on `in_byte` |
| in_byte | input | 8 | Received byte |
| out_valid | output | 1 | `out_byte` carries a payload byte |
| out_byte | output | 8 | Forwarded payload byte |
| done | output | 1 | Transfer finished cleanly (pulse) |
| miss_err | output | 1 | Start byte not found within the window (pulse) |
| crc_err | output | 1 | Check bytes did not match (pulse) |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest situation to reach is an abort part-way through a block read. Here the early packets complete and a later packet's check bytes are corrupted, so the payload already forwarded must stay intact and no `done` may appear. The bench builds a three-packet read from a byte pattern and corrupts only the low check byte of the second packet. It also runs the search windows exactly at their limits: 7 and 99 fillers must succeed, while 8 and 100 fillers must fail.

// File: rtl/rdtag_rx.sv
module rdtag_rx #(
  parameter int PKT_BYTES  = 256,
  parameter int SINGLE_WIN = 8,
  parameter int BLOCK_WIN  = 100,
  parameter int LENW       = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            single_rd,
  input  logic            clockless,
  input  logic            crc_on,
  input  logic [LENW-1:0] blk_len,
  input  logic            in_valid,
  input  logic [7:0]      in_byte,
  output logic            out_valid,
  output logic [7:0]      out_byte,
  output logic            done,
  output logic            miss_err,
  output logic            crc_err,
  output logic            busy
);

  localparam int MAXWIN = (SINGLE_WIN > BLOCK_WIN) ? SINGLE_WIN : BLOCK_WIN;
  localparam int HW = $clog2(MAXWIN + 1);
  localparam int PW = $clog2(PKT_BYTES + 1);
  localparam int SINGLE_BYTES = 4;

  typedef enum logic [2:0] {S_IDLE, S_HUNT, S_DATA, S_CRCH, S_CRCL} st_t;

  st_t             st;
  logic            is_single, chk;
  logic [LENW-1:0] rem;
  logic [PW-1:0]   pkt_left;
  logic [HW-1:0]   hunt_cnt;
  logic [15:0]     crc;
  logic [7:0]      crc_hi;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] x;
    x = c;
    for (int i = 7; i >= 0; i--)
      x = (x[15] ^ d[i]) ? ({x[14:0], 1'b0} ^ 16'h1021) : {x[14:0], 1'b0};
    return x;
  endfunction

  wire tag_seen = (in_byte[7:4] == 4'hF);
  wire win_last = is_single ? (hunt_cnt == HW'(SINGLE_WIN - 1))
                            : (hunt_cnt == HW'(BLOCK_WIN - 1));
  wire [PW-1:0] first_pkt = is_single ? PW'(SINGLE_BYTES)
                          : ((rem > LENW'(PKT_BYTES)) ? PW'(PKT_BYTES) : PW'(rem));

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      is_single <= 1'b0;
      chk       <= 1'b0;
      rem       <= '0;
      pkt_left  <= '0;
      hunt_cnt  <= '0;
      crc       <= 16'hFFFF;
      crc_hi    <= 8'h00;
      out_valid <= 1'b0;
      out_byte  <= 8'h00;
      done      <= 1'b0;
      miss_err  <= 1'b0;
      crc_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      miss_err  <= 1'b0;
      crc_err   <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          is_single <= single_rd;
          chk       <= crc_on && !(single_rd && clockless);
          rem       <= single_rd ? LENW'(SINGLE_BYTES) : blk_len;
          hunt_cnt  <= '0;
          if (!single_rd && blk_len == '0) done <= 1'b1;
          else                             st   <= S_HUNT;
        end
        S_HUNT: if (in_valid) begin
          if (tag_seen) begin
            st       <= S_DATA;
            pkt_left <= first_pkt;
            crc      <= 16'hFFFF;
          end else if (win_last) begin
            miss_err <= 1'b1;
            st       <= S_IDLE;
          end else begin
            hunt_cnt <= hunt_cnt + 1'b1;
          end
        end
        S_DATA: if (in_valid) begin
          out_valid <= 1'b1;
          out_byte  <= in_byte;
          crc       <= crc_step(crc, in_byte);
          rem       <= rem - 1'b1;
          pkt_left  <= pkt_left - 1'b1;
          if (pkt_left == PW'(1)) begin
            hunt_cnt <= '0;
            if (chk)                    st <= S_CRCH;
            else if (rem == LENW'(1)) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else                    st <= S_HUNT;
          end
        end
        S_CRCH: if (in_valid) begin
          crc_hi <= in_byte;
          st     <= S_CRCL;
        end
        S_CRCL: if (in_valid) begin
          if ({crc_hi, in_byte} != crc) begin
            crc_err <= 1'b1;
            st      <= S_IDLE;
          end else if (rem == '0) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            st <= S_HUNT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, miss_err, crc_err}));

  a_r9_idle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done || miss_err || crc_err) |-> !busy);

  a_r2_valid_from_payload: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(st == S_DATA && in_valid));

  a_r3_miss_from_search: assert property (@(posedge clk) disable iff (!rst_n)
    miss_err |-> $past(st == S_HUNT && in_valid && !tag_seen));

  a_r7_crcerr_from_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> $past(st == S_CRCL && in_valid));

  a_r10_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HUNT && start && !in_valid) |=> (st == S_HUNT && $stable(rem)));

endmodule

// File: tb/rdtag_rx_tb_top.sv
module rdtag_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PKT = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, single_rd = 0, clockless = 0, crc_on = 0;
  logic [15:0] blk_len = '0;
  logic in_valid = 0;
  logic [7:0] in_byte = '0;
  logic out_valid, done, miss_err, crc_err, busy;
  logic [7:0] out_byte;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdtag_rx #(.PKT_BYTES(PKT), .SINGLE_WIN(8), .BLOCK_WIN(100), .LENW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .single_rd(single_rd),
    .clockless(clockless), .crc_on(crc_on), .blk_len(blk_len),
    .in_valid(in_valid), .in_byte(in_byte), .out_valid(out_valid),
    .out_byte(out_byte), .done(done), .miss_err(miss_err),
    .crc_err(crc_err), .busy(busy));

  int checks = 0, errors = 0;
  int got_n, n_done, n_miss, n_crc;
  logic [7:0] got [0:63];
  logic [7:0] pat [0:63];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int off, input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      c = c ^ {pat[off+k], 8'h00};
      for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic sample();
    if (out_valid && got_n < 64) begin got[got_n] = out_byte; got_n++; end
    if (done) n_done++;
    if (miss_err) n_miss++;
    if (crc_err) n_crc++;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); in_valid = 1; in_byte = b;
    @(posedge clk); #1; in_valid = 0; sample();
  endtask

  task automatic idle_cyc();
    @(posedge clk); #1; sample();
  endtask

  task automatic begin_xfer(input bit s, input bit cl, input bit c, input int len);
    got_n = 0; n_done = 0; n_miss = 0; n_crc = 0;
    @(negedge clk);
    start = 1; single_rd = s; clockless = cl; crc_on = c; blk_len = 16'(len);
    @(posedge clk); #1; start = 0; sample();
  endtask

  task automatic send_pkt(input int off, input int n, input int nfill,
                          input logic [7:0] fillv, input logic [7:0] tagv,
                          input bit c, input bit bad);
    logic [15:0] cc;
    for (int i = 0; i < nfill; i++) send(fillv);
    send(tagv);
    for (int i = 0; i < n; i++) send(pat[off+i]);
    if (c) begin
      cc = ref_crc(off, n);
      send(cc[15:8]);
      send(cc[7:0] ^ (bad ? 8'h01 : 8'h00));
    end
  endtask

  function automatic bit match(input int off, input int n);
    for (int i = 0; i < n; i++) if (got[i] !== pat[off+i]) return 0;
    return 1;
  endfunction

  task automatic t_reset();
    chk(!busy && !out_valid, "R1 busy/valid after reset", {busy, out_valid}, 0);
    chk(!done && !miss_err && !crc_err, "R1 flags after reset", {done, miss_err, crc_err}, 0);
  endtask

  task automatic t_idle_ignore();
    got_n = 0; n_done = 0;
    send(8'hF1); send(8'h22); send(8'h33);
    chk(got_n == 0 && !busy, "R10 idle bytes ignored", got_n, 0);
  endtask

  task automatic t_single_plain();
    begin_xfer(1, 0, 0, 0);
    send(8'hF3);
    for (int i = 0; i < 3; i++) send(pat[i]);
    chk(!done, "R9 no done before last byte", done, 0);
    send(pat[3]);
    chk(done && !busy, "R9 done with last byte", {done, busy}, 2);
    idle_cyc();
    chk(!done, "R9 done is one cycle", done, 0);
    chk(got_n == 4 && match(0, 4), "R4 single payload", got_n, 4);
  endtask

  task automatic t_single_fill_limit();
    begin_xfer(1, 0, 1, 0);
    send_pkt(4, 4, 7, 8'hE5, 8'hF0, 1, 0);
    chk(got_n == 4 && match(4, 4), "R2 skip 7 fillers, tag F0", got_n, 4);
    chk(n_done == 1 && n_crc == 0, "R7 single crc ok", n_crc, 0);
    begin_xfer(1, 0, 0, 0);
    for (int i = 0; i < 7; i++) send(8'h00);
    chk(n_miss == 0 && busy, "R3 still searching after 7", n_miss, 0);
    send(8'h00);
    chk(miss_err && !busy, "R3 miss on 8th filler", {miss_err, busy}, 2);
    chk(got_n == 0, "R3 no payload on miss", got_n, 0);
  endtask

  task automatic t_single_crc();
    begin_xfer(1, 0, 1, 0);
    send_pkt(8, 4, 2, 8'h00, 8'hFF, 1, 1);
    chk(n_crc == 1 && n_done == 0 && !busy, "R7 single crc mismatch", n_crc, 1);
    begin_xfer(1, 1, 1, 0);
    send_pkt(8, 4, 1, 8'h00, 8'hF7, 0, 0);
    chk(n_done == 1 && !busy, "R8 clockless skips crc", n_done, 1);
    send(8'h12);
    chk(got_n == 4 && n_crc == 0, "R8 trailing byte ignored", got_n, 4);
  endtask

  task automatic t_block_ok();
    begin_xfer(0, 0, 1, 40);
    send_pkt(0, 16, 3, 8'h00, 8'hF3, 1, 0);
    chk(busy && n_done == 0, "R5 busy between packets", busy, 1);
    send_pkt(16, 16, 0, 8'h00, 8'hF3, 1, 0);
    send_pkt(32, 8, 5, 8'h0A, 8'hF3, 1, 0);
    chk(got_n == 40 && match(0, 40), "R5 block payload 40 bytes", got_n, 40);
    chk(n_done == 1 && n_crc == 0 && !busy, "R7 block crc ok", n_done, 1);
  endtask

  task automatic t_block_crc_abort();
    begin_xfer(0, 0, 1, 40);
    send_pkt(0, 16, 0, 8'h00, 8'hF3, 1, 0);
    send_pkt(16, 16, 2, 8'h00, 8'hF3, 1, 1);
    chk(n_crc == 1 && !busy, "R7 second packet crc abort", n_crc, 1);
    send(8'hF3); send(8'h55);
    chk(got_n == 32 && n_done == 0 && match(0, 32), "R7 no data after abort", got_n, 32);
  endtask

  task automatic t_block_window();
    begin_xfer(0, 0, 0, 4);
    send_pkt(0, 4, 99, 8'h00, 8'hF3, 0, 0);
    chk(n_done == 1 && got_n == 4 && n_miss == 0, "R6 99 fillers accepted", got_n, 4);
    begin_xfer(0, 0, 0, 4);
    for (int i = 0; i < 100; i++) send(8'h00);
    chk(n_miss == 1 && !busy && got_n == 0, "R6 miss after 100 fillers", n_miss, 1);
  endtask

  task automatic t_start_busy();
    begin_xfer(1, 0, 0, 0);
    send(8'h00);
    @(negedge clk); start = 1; single_rd = 0; crc_on = 1; blk_len = 16'd40;
    @(posedge clk); #1; start = 0; sample();
    send_pkt(0, 4, 0, 8'h00, 8'hF3, 0, 0);
    chk(n_done == 1 && got_n == 4 && !busy, "R10 start while busy ignored", got_n, 4);
  endtask

  task automatic t_zero_len();
    begin_xfer(0, 0, 0, 0);
    chk(done && !busy, "R11 zero-length done", {done, busy}, 2);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) pat[i] = 8'((i * 37 + 11) ^ (i << 2));
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1;
    t_idle_ignore();
    t_single_plain();
    t_single_fill_limit();
    t_single_crc();
    t_block_ok();
    t_block_crc_abort();
    t_block_window();
    t_start_busy();
    t_zero_len();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule